// File: doc/BRIEF.md
# Token-Bus Link Controller

This block is the link-layer control machine for one station on a token-passing bus. A byte-level receiver in front of it delivers the received bytes with a frame-start strobe, an end-of-frame strobe and a CRC verdict. A frame encoder behind it is told which frame to send and to whom, and it reports back when that frame has gone out. The controller decodes the frame kind and the doubled destination byte. It answers buffer enquiries, takes in and acknowledges data packets, passes the token to its successor, and sends one queued host packet whenever it holds the token.

The host side is reduced to two mailbox flags and two pulses. `tx_pending` says an outgoing packet is waiting, and `tx_sent` reports that the packet was delivered and acknowledged. `rx_full` says the incoming slot is occupied, and `rx_store` tells the host that a packet has just been accepted into that slot. Timing uses one cycle counter. It measures line silence before the node listens for a new frame, and it bounds every wait for a reply or for the successor to start talking. The reply bound is given at run time on `tmo_limit`.

Top module: `token_link_fsm`

## Requirements
- R1: While reset is held and after it, the state output reads 0 and a reconfiguration burst is requested (`tx_req`=1, `tx_kind`=0). When `tx_done` is seen, the state becomes 1, wait for idle. State codes: 0 reset, 1 wait idle, 2 wait activity, 3 decode type, 4 decode destination, 5 reconfigure, 6 answer enquiry, 7 pass token, 8 watch after token, 9 send enquiry, 10 wait enquiry reply, 11 send packet, 12 wait packet reply, 13 receive packet, 14 send acknowledge.
- R2: State 1 moves to state 2 after exactly IDLE_CYC consecutive cycles with `line_active` low. Any cycle with `line_active` high restarts that count.
- R3: In state 2, `rx_sof` leads to state 3. The first byte is the type: 0x04 token, 0x85 buffer enquiry, 0x01 packet. Any other type, including 0x86 acknowledge and 0x15 negative acknowledge, returns to state 1. The two following bytes are the destination. The frame is addressed to this node only when both bytes equal `my_id`. An unaddressed frame returns to state 1 with no transmit request.
- R4: An addressed buffer enquiry leads to state 6. In the cycle after the last destination byte, an acknowledge (`tx_kind`=3) is requested if `rx_full` is low, or a negative acknowledge (`tx_kind`=4) if it is high. After `tx_done` the state is 1.
- R5: An addressed packet leads to state 13. At `rx_end`, if `rx_crc_ok` is high and `rx_full` is low, `rx_store` pulses in the next cycle and an acknowledge (`tx_kind`=3) is requested in state 14. Otherwise the state returns to 1 with no pulse and no acknowledge.
- R6: An addressed token with `tx_pending` low leads to state 7. There a token (`tx_kind`=1) is requested to `next_id`, and after `tx_done` the state is 8.
- R7: In state 8, `line_active` high returns to state 1. If `line_active` stays low for `tmo_limit` cycles, the state becomes 5 and a reconfiguration burst (`tx_kind`=0) is requested; after `tx_done` the state is 1.
- R8: An addressed token with `tx_pending` high leads to state 9, which requests a buffer enquiry (`tx_kind`=2) to `pkt_dest`, then to state 10. In state 10, a reply byte 0x86 leads to state 11, which requests a packet (`tx_kind`=5) to `pkt_dest`. A reply byte 0x15, or `tmo_limit` silent cycles, leads to state 7 with no packet sent.
- R9: In state 12, a reply byte 0x86 pulses `tx_sent` for one cycle and enters state 7. If `tmo_limit` silent cycles pass first, the state becomes 7 and `tx_sent` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| rx_sof | input | 1 | frame-start strobe from the receiver |
| rx_valid | input | 1 | received byte valid |
| rx_byte | input | 8 | received byte |
| rx_end | input | 1 | end of a received packet |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_end |
| line_active | input | 1 | carrier seen on the line |
| my_id | input | 8 | this node's address |
| next_id | input | 8 | successor's address |
| tmo_limit | input | TW | reply and token-watch timeout in cycles |
| tx_req | output | 1 | frame transmit request, held until tx_done |
| tx_kind | output | 3 | frame kind: 0 reconfig, 1 token, 2 enquiry, 3 ack, 4 nak, 5 packet |
| tx_dest | output | 8 | destination for token, enquiry and packet |
| tx_done | input | 1 | encoder finished the requested frame |
| tx_pending | input | 1 | host packet waiting to be sent |
| pkt_dest | input | 8 | destination of the host packet |
| tx_sent | output | 1 | pulse: host packet acknowledged |
| rx_full | input | 1 | incoming mailbox occupied |
| rx_store | output | 1 | pulse: received packet accepted |
| state_o | output | 4 | current state code |

## Verification
The bench builds the controller with IDLE_CYC=4 and drives `tmo_limit` at 12, so every silence and timeout window closes in a few cycles. This lets the bench count exact window lengths. It also lets it sweep every combination of six type codes, three destination patterns, pending flag and mailbox state, and follow each one through its response back to the idle wait. Directed runs cover the full enquiry-packet-acknowledge exchange, refused and unanswered enquiries, an unacknowledged packet, a silent successor and a packet with a bad CRC.

// File: rtl/token_link_fsm.sv
module token_link_fsm #(
  parameter int IDLE_CYC = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_sof,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_end,
  input  logic          rx_crc_ok,
  input  logic          line_active,
  input  logic [7:0]    my_id,
  input  logic [7:0]    next_id,
  input  logic [TW-1:0] tmo_limit,
  output logic          tx_req,
  output logic [2:0]    tx_kind,
  output logic [7:0]    tx_dest,
  input  logic          tx_done,
  input  logic          tx_pending,
  input  logic [7:0]    pkt_dest,
  output logic          tx_sent,
  input  logic          rx_full,
  output logic          rx_store,
  output logic [3:0]    state_o
);
  localparam logic [3:0] S_RESET = 4'd0, S_WT_IDLE = 4'd1, S_WT_ACT = 4'd2, S_DEC_TYPE = 4'd3,
                         S_DEC_DST = 4'd4, S_RECON = 4'd5, S_ANS_ENQ = 4'd6, S_PASS = 4'd7,
                         S_WT_TOK = 4'd8, S_TX_ENQ = 4'd9, S_WT_ENQ = 4'd10, S_TX_PKT = 4'd11,
                         S_WT_PKT = 4'd12, S_RX_PKT = 4'd13, S_TX_ACK = 4'd14;
  localparam logic [7:0] T_TOKEN = 8'h04, T_ENQ = 8'h85, T_ACK = 8'h86, T_NAK = 8'h15, T_PKT = 8'h01;
  localparam logic [2:0] K_RECON = 3'd0, K_TOKEN = 3'd1, K_ENQ = 3'd2, K_ACK = 3'd3,
                         K_NAK = 3'd4, K_PKT = 3'd5;
  localparam logic [TW-1:0] IDLE_LAST = TW'(IDLE_CYC - 1);

  logic [3:0]    state, nxt;
  logic [TW-1:0] cnt;
  logic [7:0]    typ, did1;
  logic          got1;

  wire idle_hit  = !line_active && cnt == IDLE_LAST;
  wire tmo_hit   = !line_active && ({1'b0, cnt} + 1'b1) >= {1'b0, tmo_limit};
  wire reply_ack = rx_valid && rx_byte == T_ACK;
  wire reply_nak = rx_valid && rx_byte == T_NAK;
  wire for_me    = rx_byte == did1 && rx_byte == my_id;
  wire known     = rx_byte == T_TOKEN || rx_byte == T_ENQ || rx_byte == T_PKT;

  always_comb begin
    nxt = state;
    case (state)
      S_RESET:    if (tx_done) nxt = S_WT_IDLE;
      S_WT_IDLE:  if (idle_hit) nxt = S_WT_ACT;
      S_WT_ACT:   if (rx_sof) nxt = S_DEC_TYPE;
      S_DEC_TYPE: if (rx_valid) nxt = known ? S_DEC_DST : S_WT_IDLE;
      S_DEC_DST:
        if (rx_valid && got1) begin
          if (!for_me) nxt = S_WT_IDLE;
          else if (typ == T_TOKEN) nxt = tx_pending ? S_TX_ENQ : S_PASS;
          else if (typ == T_ENQ) nxt = S_ANS_ENQ;
          else nxt = S_RX_PKT;
        end
      S_RECON, S_ANS_ENQ, S_TX_ACK: if (tx_done) nxt = S_WT_IDLE;
      S_PASS:     if (tx_done) nxt = S_WT_TOK;
      S_WT_TOK:   if (line_active) nxt = S_WT_IDLE; else if (tmo_hit) nxt = S_RECON;
      S_TX_ENQ:   if (tx_done) nxt = S_WT_ENQ;
      S_WT_ENQ:   if (reply_ack) nxt = S_TX_PKT; else if (reply_nak || tmo_hit) nxt = S_PASS;
      S_TX_PKT:   if (tx_done) nxt = S_WT_PKT;
      S_WT_PKT:   if (reply_ack || reply_nak || tmo_hit) nxt = S_PASS;
      S_RX_PKT:   if (rx_end) nxt = (rx_crc_ok && !rx_full) ? S_TX_ACK : S_WT_IDLE;
      default:    nxt = S_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_RESET;
      cnt      <= '0;
      typ      <= '0;
      did1     <= '0;
      got1     <= 1'b0;
      tx_sent  <= 1'b0;
      rx_store <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state || line_active) cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
      if (state == S_DEC_TYPE) begin
        got1 <= 1'b0;
        if (rx_valid) typ <= rx_byte;
      end else if (state == S_DEC_DST && rx_valid && !got1) begin
        did1 <= rx_byte;
        got1 <= 1'b1;
      end
      tx_sent  <= state == S_WT_PKT && reply_ack;
      rx_store <= state == S_RX_PKT && rx_end && rx_crc_ok && !rx_full;
    end
  end

  assign state_o = state;
  assign tx_req = state == S_RESET || state == S_RECON || state == S_ANS_ENQ || state == S_PASS ||
                  state == S_TX_ENQ || state == S_TX_PKT || state == S_TX_ACK;

  always_comb begin
    case (state)
      S_PASS:    tx_kind = K_TOKEN;
      S_TX_ENQ:  tx_kind = K_ENQ;
      S_TX_PKT:  tx_kind = K_PKT;
      S_TX_ACK:  tx_kind = K_ACK;
      S_ANS_ENQ: tx_kind = rx_full ? K_NAK : K_ACK;
      default:   tx_kind = K_RECON;
    endcase
  end

  assign tx_dest = (state == S_PASS) ? next_id :
                   (state == S_TX_ENQ || state == S_TX_PKT) ? pkt_dest : 8'h00;

  a_r2_idle_needs_silence: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WT_ACT && $past(state) == S_WT_IDLE) |-> !$past(line_active));
  a_r5_ack_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    rx_store |-> (state == S_TX_ACK && tx_req && tx_kind == K_ACK));
  a_r6_token_to_next: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_kind == K_TOKEN) |-> tx_dest == next_id);
  a_r7_watch_ends_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_WT_TOK && state == S_WT_IDLE) |-> $past(line_active));
  a_r8_packet_only_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX_PKT && $past(state) != S_TX_PKT) |-> $past(state) == S_WT_ENQ);
  a_r9_sent_passes_token: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sent |-> (state == S_PASS && $past(state) == S_WT_PKT));
endmodule

// File: tb/token_link_fsm_test.sv
module token_link_fsm_test;
  localparam int IDLE = 4;
  localparam int TMO = 12;
  localparam logic [7:0] MY = 8'h2C, NX = 8'h31, PD = 8'h47;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_sof = 0, rx_valid = 0, rx_end = 0, rx_crc_ok = 0, line_active = 0;
  logic [7:0] rx_byte = 0;
  logic tx_req, tx_sent, rx_store, tx_done = 0, tx_pending = 0, rx_full = 0;
  logic [2:0] tx_kind;
  logic [7:0] tx_dest;
  logic [3:0] state_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  token_link_fsm #(.IDLE_CYC(IDLE), .TW(16)) uut (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .line_active(line_active), .my_id(MY),
    .next_id(NX), .tmo_limit(16'(TMO)), .tx_req(tx_req), .tx_kind(tx_kind), .tx_dest(tx_dest),
    .tx_done(tx_done), .tx_pending(tx_pending), .pkt_dest(PD), .tx_sent(tx_sent),
    .rx_full(rx_full), .rx_store(rx_store), .state_o(state_o));

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_tx();
    tx_done = 1; step(); tx_done = 0;
  endtask

  task automatic count_in(input logic [3:0] s, output int n);
    n = 0;
    while (state_o == s && n < 1000) begin step(); n++; end
  endtask

  task automatic go_idle();
    int n;
    count_in(4'd1, n);
    chk(state_o == 4'd2, "R2 idle wait ends", state_o, 2);
  endtask

  task automatic send_frame(input logic [7:0] t, input logic [7:0] d1, input logic [7:0] d2);
    line_active = 1; rx_sof = 1; step(); rx_sof = 0;
    rx_valid = 1; rx_byte = t; step();
    rx_byte = d1; step();
    rx_byte = d2; step();
    rx_valid = 0; line_active = 0;
  endtask

  task automatic send_reply(input logic [7:0] b);
    line_active = 1; rx_sof = 1; step(); rx_sof = 0;
    rx_valid = 1; rx_byte = b; step();
    rx_valid = 0; line_active = 0;
  endtask

  task automatic pass_token_ok();
    chk(state_o == 4'd7 && tx_req && tx_kind == 3'd1 && tx_dest == NX, "R6 token request",
        {state_o, tx_kind, tx_dest}, {4'd7, 3'd1, NX});
    finish_tx();
    chk(state_o == 4'd8, "R6 watch after token", state_o, 8);
    line_active = 1; step(); line_active = 0;
    chk(state_o == 4'd1, "R7 activity ends watch", state_o, 1);
    go_idle();
  endtask

  function automatic int exp_state(input logic [7:0] t, input logic [7:0] d1,
                                   input logic [7:0] d2, input bit pend);
    if (t != 8'h04 && t != 8'h85 && t != 8'h01) return 1;
    if (d1 != MY || d2 != MY) return 1;
    if (t == 8'h85) return 6;
    if (t == 8'h01) return 13;
    return pend ? 9 : 7;
  endfunction

  initial begin
    logic [7:0] types [6];
    int n, e;
    types = '{8'h04, 8'h85, 8'h86, 8'h15, 8'h01, 8'h5A};
    step(); step();
    chk(state_o == 0 && tx_req && tx_kind == 3'd0, "R1 reset burst", {state_o, tx_kind}, 0);
    rst_n = 1; step(); step();
    chk(state_o == 0 && tx_req && tx_kind == 3'd0, "R1 burst held", state_o, 0);
    finish_tx();
    chk(state_o == 1, "R1 wait idle after burst", state_o, 1);
    line_active = 1;
    for (int i = 0; i < 10; i++) step();
    chk(state_o == 1, "R2 activity holds idle wait", state_o, 1);
    line_active = 0;
    count_in(4'd1, n);
    chk(n == IDLE && state_o == 2, "R2 silence length", n, IDLE);

    for (int ti = 0; ti < 6; ti++)
      for (int dp = 0; dp < 3; dp++)
        for (int pf = 0; pf < 4; pf++) begin
          logic [7:0] d1, d2;
          d1 = (dp == 1) ? NX : MY;
          d2 = (dp == 0) ? MY : NX;
          tx_pending = pf[0]; rx_full = pf[1];
          send_frame(types[ti], d1, d2);
          e = exp_state(types[ti], d1, d2, pf[0]);
          chk(state_o == 4'(e), "R3 decode result", state_o, e);
          case (e)
            1: begin
              chk(!tx_req, "R3 unaddressed silent", tx_req, 0);
              go_idle();
            end
            6: begin
              chk(tx_req && tx_kind == (pf[1] ? 3'd4 : 3'd3), "R4 enquiry answer",
                  tx_kind, pf[1] ? 4 : 3);
              finish_tx();
              chk(state_o == 1, "R4 back to idle", state_o, 1);
              go_idle();
            end
            7: pass_token_ok();
            9: begin
              chk(tx_req && tx_kind == 3'd2 && tx_dest == PD, "R8 enquiry request",
                  {tx_kind, tx_dest}, {3'd2, PD});
              finish_tx();
              count_in(4'd10, n);
              chk(n == TMO && state_o == 7, "R8 enquiry timeout", n, TMO);
              pass_token_ok();
            end
            13: begin
              rx_crc_ok = 1; rx_end = 1; step(); rx_end = 0;
              if (!pf[1]) begin
                chk(rx_store && state_o == 14 && tx_req && tx_kind == 3'd3, "R5 store and ack",
                    {rx_store, state_o}, {1'b1, 4'd14});
                finish_tx();
              end else
                chk(!rx_store && state_o == 1, "R5 full mailbox no ack",
                    {rx_store, state_o}, 1);
              go_idle();
            end
            default: ;
          endcase
        end

    tx_pending = 1; rx_full = 0;
    send_frame(8'h04, MY, MY); finish_tx();
    send_reply(8'h86);
    chk(state_o == 11 && tx_req && tx_kind == 3'd5 && tx_dest == PD, "R8 packet request",
        {state_o, tx_kind}, {4'd11, 3'd5});
    finish_tx();
    chk(state_o == 12, "R8 wait packet reply", state_o, 12);
    send_reply(8'h86);
    chk(tx_sent && state_o == 7, "R9 packet acknowledged", {tx_sent, state_o}, {1'b1, 4'd7});
    pass_token_ok();

    send_frame(8'h04, MY, MY); finish_tx();
    send_reply(8'h15);
    chk(state_o == 7 && tx_kind == 3'd1, "R8 refused enquiry skips packet", state_o, 7);
    pass_token_ok();

    send_frame(8'h04, MY, MY); finish_tx();
    send_reply(8'h86); finish_tx();
    count_in(4'd12, n);
    chk(n == TMO && state_o == 7 && !tx_sent, "R9 packet reply timeout", n, TMO);
    pass_token_ok();

    tx_pending = 0;
    send_frame(8'h04, MY, MY); finish_tx();
    count_in(4'd8, n);
    chk(n == TMO && state_o == 5 && tx_req && tx_kind == 3'd0, "R7 silent successor", n, TMO);
    finish_tx();
    chk(state_o == 1, "R7 reconfig done", state_o, 1);
    go_idle();

    send_frame(8'h01, MY, MY);
    rx_crc_ok = 0; rx_end = 1; step(); rx_end = 0;
    chk(!rx_store && state_o == 1 && !tx_req, "R5 bad crc not acked", {rx_store, state_o}, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule